// File: doc/BRIEF.md
# Dual-Ramp Shift-Compensating Linearity Estimator

This block turns two code histograms from an ADC under test into estimates of its integral and differential nonlinearity. Both histograms come from the same monotonic but nonlinear ramp. The second run has the ramp moved by a constant whose size is not known. Comparing partial sums of the first histogram with partial sums of the second, taken one code lower, cancels the ramp's own bending. The unknown offset is then found in closed form, because INL must be zero at both end codes.

Software or a capture engine fills the two tally banks through a code/count write port and then pulses `start`. The block makes two passes over the codes. A single shared iterative divider serves both passes. The first pass stores one reciprocal slope term per code and adds up their sum. One more division then gives the offset in LSB. The second pass streams INL and DNL out, one code per cycle in ascending order, and tracks the largest magnitudes. All results are signed Q16.16 numbers, that is, integer value times 65536, wrapped to 32 bits. If any code produces an unusable term, a sticky flag marks the whole run as invalid.

Top module: `dramp_lin_est`

## Requirements
- R1: A cycle with `wr_en`=1 stores `wr_count` as the tally of code `wr_code`. When `wr_sel`=0 the value goes to the first-run bank A. When `wr_sel`=1 it goes to the shifted-run bank B. Results use A_k and B_k exactly as written.
- R2: Take D_k = (A_0+..+A_k) − (B_0+..+B_{k−1}). For each k = 1..N−2, with N = 2^NBITS, the term is r_k = floor(2^17·A_k·B_{k−1} / ((A_k+B_{k−1})·D_k)), kept to 32 bits. `shift_est` = floor((N−2)·2^32 / Σr_k), kept to 32 bits.
- R3: The DNL of beat k is floor(shift_est·r_k / 2^16) mod 2^32, minus 65536.
- R4: The INL of beat k, for k = 1..N−3, is floor(shift_est·R_k / 2^16) mod 2^32, minus k·65536. Here R_k = (r_1+..+r_k) mod 2^32. The INL of beat N−2 is exactly 0.
- R5: Each run gives exactly N−2 beats, with `res_valid` high on consecutive cycles. `res_code` runs 1, 2, .., N−2.
- R6: `busy` rises at the clock edge that samples `start`. It stays high through the cycle of the last beat and is low in the cycle after that. A `start` seen while `busy` is high has no effect.
- R7: Once `busy` falls, `inl_max` and `dnl_max` hold the largest unsigned magnitude |x| of the streamed INL and DNL values.
- R8: A term is bad when A_k = 0, B_{k−1} = 0 or D_k ≤ 0. Each bad term sets `err`, is taken as r_k = 0, and does not stop the run. `err` stays set until the next accepted `start` clears it.
- R9: If every term is bad, so that Σr_k = 0, `shift_est` is 0 and `err` is 1.
- R10: After reset, `busy`, `res_valid`, `err`, `shift_est`, `inl_max` and `dnl_max` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Tally write strobe |
| wr_sel | input | 1 | Bank select: 0 first run, 1 shifted run |
| wr_code | input | NBITS | Code index of the write |
| wr_count | input | CW | Tally value |
| start | input | 1 | Starts an estimation run |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | Result beat present |
| res_code | output | NBITS | Code index of the beat |
| res_inl | output | 32 | INL of the beat, signed Q16.16 |
| res_dnl | output | 32 | DNL of the beat, signed Q16.16 |
| shift_est | output | 32 | Estimated ramp offset in LSB, Q16.16 |
| inl_max | output | 32 | Largest INL magnitude, Q16.16 |
| dnl_max | output | 32 | Largest DNL magnitude, Q16.16 |
| err | output | 1 | Sticky invalid-result flag |

## Verification
The divider checks assume that it is never given a zero divisor. They also assume it is never restarted while a quotient is still in progress. The block guarantees both by screening every term, and the empty sum, before it issues a division. The checks on beat order and on the sticky flag assume that the tally banks do not change during a run. The bench therefore loads every tally while the block is idle. Its tallies are built from a base count plus a bounded ripple, with the first-run code 0 raised by a lag of 150 to 400 counts, which keeps D_k well above zero. Zero tallies and an oversized shifted-run code 0 are written only in the tests aimed at the error path.

// File: rtl/dramp_pkg.sv
package dramp_pkg;

  localparam int QF = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SCAN, PH_SCANW, PH_NORM, PH_NORMW, PH_EMIT, PH_FIN
  } phase_t;

  // numerator of the reciprocal slope term, already scaled by 2^(QF+1)
  function automatic logic [63:0] recip_num(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p << (QF + 1);
  endfunction

  // denominator: (a+b) times the cross-shifted partial-sum difference
  function automatic logic [63:0] recip_den(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] d);
    return (64'(a) + 64'(b)) * 64'(d);
  endfunction

  // Q16.16 product, low 32 bits of the rescaled result
  function automatic logic [31:0] qmul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p[47:16];
  endfunction

  function automatic logic [31:0] mag(input logic [31:0] x);
    return x[31] ? (~x + 32'd1) : x;
  endfunction

endpackage

// File: rtl/dramp_tally.sv
module dramp_tally #(
  parameter int NB = 6,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          sel,
  input  logic [NB-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [NB-1:0] ra_up,
  input  logic [NB-1:0] ra_dn,
  output logic [CW-1:0] rd_up,
  output logic [CW-1:0] rd_dn
);
  localparam int NE = 1 << NB;

  logic [CW-1:0] bank_a [NE];
  logic [CW-1:0] bank_b [NE];

  always_ff @(posedge clk) begin
    if (we && !sel) bank_a[waddr] <= wdata;
    if (we && sel)  bank_b[waddr] <= wdata;
  end

  assign rd_up = bank_a[ra_up];
  assign rd_dn = bank_b[ra_dn];

endmodule

// File: rtl/dramp_div.sv
module dramp_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CNW = $clog2(W + 1);

  logic [W:0]     acc;
  logic [W-1:0]   qr;
  logic [W-1:0]   dv;
  logic [CNW-1:0] cnt;
  logic           run;
  logic [W:0]     trial;
  logic           fits;

  always_comb begin
    trial = {acc[W-1:0], qr[W-1]};
    fits  = trial >= {1'b0, dv};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      qr  <= '0;
      dv  <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc <= '0;
        qr  <= num;
        dv  <= den;
        cnt <= CNW'(W);
        run <= 1'b1;
      end else if (run) begin
        acc <= fits ? (trial - {1'b0, dv}) : trial;
        qr  <= {qr[W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = qr;

  // the remainder left over must be smaller than the divisor (R2 arithmetic)
  p_rem_below_den_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (acc < {1'b0, dv}));

  // the shared divider is never restarted while it is still iterating
  p_single_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run);

endmodule

// File: rtl/dramp_lin_est.sv
module dramp_lin_est
  import dramp_pkg::*;
#(
  parameter int NBITS = 6,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [NBITS-1:0] wr_code,
  input  logic [CW-1:0]    wr_count,
  input  logic             start,
  output logic             busy,
  output logic             res_valid,
  output logic [NBITS-1:0] res_code,
  output logic [31:0]      res_inl,
  output logic [31:0]      res_dnl,
  output logic [31:0]      shift_est,
  output logic [31:0]      inl_max,
  output logic [31:0]      dnl_max,
  output logic             err
);
  localparam int NE   = 1 << NBITS;
  localparam int LAST = NE - 2;
  localparam int SUMW = 32 + NBITS;
  localparam logic [NBITS-1:0] KLAST = NBITS'(LAST);

  phase_t           st;
  logic [NBITS-1:0] k;
  logic [31:0]      s1, s2, cum, alpha;
  logic [SUMW-1:0]  sumr;
  logic [31:0]      rcp [NE];

  logic [NBITS-1:0] ra_up, ra_dn;
  logic [CW-1:0]    c1k, c2p;
  logic [31:0]      s1n, s2n, rk, cum_n, inl_v, dnl_v, rcp_wd;
  logic [32:0]      dk;
  logic             term_bad, term_go, alpha_go, div_go, div_fin, beat_fire, rcp_we;
  logic [63:0]      div_num, div_den, div_quo;

  assign ra_up = (st == PH_IDLE) ? '0 : k;
  assign ra_dn = k - 1'b1;

  dramp_tally #(.NB(NBITS), .CW(CW)) u_tally (
    .clk(clk), .we(wr_en), .sel(wr_sel), .waddr(wr_code), .wdata(wr_count),
    .ra_up(ra_up), .ra_dn(ra_dn), .rd_up(c1k), .rd_dn(c2p)
  );

  always_comb begin
    s1n      = s1 + 32'(c1k);
    s2n      = s2 + 32'(c2p);
    dk       = {1'b0, s1n} - {1'b0, s2n};
    term_bad = (st == PH_SCAN) && (c1k == '0 || c2p == '0 || dk[32] || dk == '0);
    term_go  = (st == PH_SCAN) && !term_bad;
    alpha_go = (st == PH_NORM) && (sumr != '0);
    div_go   = term_go || alpha_go;
    div_num  = term_go ? recip_num(32'(c1k), 32'(c2p)) : (64'(LAST) << 32);
    div_den  = term_go ? recip_den(32'(c1k), 32'(c2p), dk[31:0]) : 64'(sumr);
    rk        = rcp[k];
    cum_n     = cum + rk;
    beat_fire = (st == PH_EMIT);
    inl_v     = (k == KLAST) ? '0 : (qmul(alpha, cum_n) - (32'(k) << 16));
    dnl_v     = qmul(alpha, rk) - 32'h0001_0000;
    rcp_we    = term_bad || (st == PH_SCANW && div_fin);
    rcp_wd    = term_bad ? '0 : div_quo[31:0];
  end

  dramp_div #(.W(64)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .quo(div_quo), .fin(div_fin)
  );

  always_ff @(posedge clk) begin
    if (rcp_we) rcp[k] <= rcp_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PH_IDLE; k <= '0; s1 <= '0; s2 <= '0; cum <= '0; alpha <= '0; sumr <= '0;
      err <= 1'b0; res_valid <= 1'b0; res_code <= '0; res_inl <= '0; res_dnl <= '0;
      inl_max <= '0; dnl_max <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        PH_IDLE: if (start) begin
          st <= PH_SCAN; k <= NBITS'(1); s1 <= 32'(c1k); s2 <= '0; sumr <= '0;
          cum <= '0; alpha <= '0; err <= 1'b0; inl_max <= '0; dnl_max <= '0;
        end
        PH_SCAN: begin
          s1 <= s1n;
          s2 <= s2n;
          if (term_bad) begin
            err <= 1'b1;
            if (k == KLAST) st <= PH_NORM;
            else k <= k + 1'b1;
          end else begin
            st <= PH_SCANW;
          end
        end
        PH_SCANW: if (div_fin) begin
          sumr <= sumr + SUMW'(div_quo[31:0]);
          if (k == KLAST) st <= PH_NORM;
          else begin k <= k + 1'b1; st <= PH_SCAN; end
        end
        PH_NORM: begin
          k <= NBITS'(1);
          if (sumr == '0) begin err <= 1'b1; alpha <= '0; st <= PH_EMIT; end
          else st <= PH_NORMW;
        end
        PH_NORMW: if (div_fin) begin alpha <= div_quo[31:0]; st <= PH_EMIT; end
        PH_EMIT: begin
          res_valid <= 1'b1;
          res_code  <= k;
          res_inl   <= inl_v;
          res_dnl   <= dnl_v;
          cum       <= cum_n;
          if (mag(inl_v) > inl_max) inl_max <= mag(inl_v);
          if (mag(dnl_v) > dnl_max) dnl_max <= mag(dnl_v);
          if (k == KLAST) st <= PH_FIN;
          else k <= k + 1'b1;
        end
        PH_FIN:  st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (st != PH_IDLE);
  assign shift_est = alpha;

  p_beat_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code >= NBITS'(1) && res_code <= KLAST));

  p_code_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> (res_code == $past(res_code) + 1'b1));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(err)) |-> err);

  p_bad_term_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term_bad |=> err);

  p_max_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inl_max >= mag(res_inl) && dnl_max >= mag(res_dnl)));

  p_emit_needs_idle_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> !div_fin);

endmodule

// File: tb/dramp_lin_est_bench.sv
module dramp_lin_est_bench;
  localparam int NB   = 6;
  localparam int CW   = 16;
  localparam int NE   = 1 << NB;
  localparam int LAST = NE - 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, wr_sel, start;
  logic [NB-1:0] wr_code;
  logic [CW-1:0] wr_count;
  logic busy, res_valid, err;
  logic [NB-1:0] res_code;
  logic [31:0] res_inl, res_dnl, shift_est, inl_max, dnl_max;

  dramp_lin_est #(.NBITS(NB), .CW(CW)) u_dramp_lin_est (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
    .wr_count(wr_count), .start(start), .busy(busy), .res_valid(res_valid),
    .res_code(res_code), .res_inl(res_inl), .res_dnl(res_dnl), .shift_est(shift_est),
    .inl_max(inl_max), .dnl_max(dnl_max), .err(err)
  );

  int total = 0;
  int bad   = 0;
  int unsigned c1 [NE];
  int unsigned c2 [NE];
  int          e_inl [NE];
  int          e_dnl [NE];
  logic [31:0] e_alpha, e_imax, e_dmax;
  logic        e_err;

  // per row: base count, ripple step, lag on code 0, shifted-run ripple, expected err
  localparam logic [79:0] VEC [5] = '{
    {16'd30, 16'd7,  16'd320, 16'd2, 16'd0},
    {16'd24, 16'd11, 16'd256, 16'd3, 16'd0},
    {16'd40, 16'd3,  16'd400, 16'd1, 16'd0},
    {16'd28, 16'd13, 16'd150, 16'd4, 16'd0},
    {16'd0,  16'd5,  16'd300, 16'd2, 16'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input bit sel, input int code, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_code = NB'(code); wr_count = CW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_row(input int base, input int swing, input int lag, input int wob);
    for (int i = 0; i < NE; i++) begin
      int v, p;
      v = base + (i * swing) % 19;
      if (i == 0) v += lag;
      p = (i * wob) % 5;
      c1[i] = v;
      c2[i] = (i == 0) ? base : ((v + p >= 2) ? (v + p - 2) : 0);
      wr(1'b0, i, int'(c1[i]));
      wr(1'b1, i, int'(c2[i]));
    end
  endtask

  // independent model of the requirement formulas
  task automatic model();
    longint s1, s2, d;
    logic [63:0] sr, nm, dn;
    logic [31:0] r [NE];
    logic [31:0] cum, m;
    s1 = c1[0]; s2 = 0; sr = 0; e_err = 1'b0;
    for (int i = 1; i <= LAST; i++) begin
      s1 += c1[i];
      s2 += c2[i-1];
      d = s1 - s2;
      if (c1[i] == 0 || c2[i-1] == 0 || d <= 0) begin
        e_err = 1'b1;
        r[i] = 32'd0;
      end else begin
        nm = 64'(c1[i]) * 64'(c2[i-1]) * 64'd131072;
        dn = (64'(c1[i]) + 64'(c2[i-1])) * 64'(d);
        r[i] = 32'(nm / dn);
      end
      sr += 64'(r[i]);
    end
    if (sr == 0) begin
      e_err = 1'b1;
      e_alpha = 32'd0;
    end else begin
      e_alpha = 32'((64'(LAST) * 64'h1_0000_0000) / sr);
    end
    cum = 0; e_imax = 0; e_dmax = 0;
    for (int i = 1; i <= LAST; i++) begin
      cum = cum + r[i];
      e_inl[i] = (i == LAST) ? 0 :
                 int'(32'((64'(e_alpha) * 64'(cum)) >> 16)) - i * 65536;
      e_dnl[i] = int'(32'((64'(e_alpha) * 64'(r[i])) >> 16)) - 65536;
      m = 32'((e_inl[i] < 0) ? -e_inl[i] : e_inl[i]);
      if (m > e_imax) e_imax = m;
      m = 32'((e_dnl[i] < 0) ? -e_dnl[i] : e_dnl[i]);
      if (m > e_dmax) e_dmax = m;
    end
  endtask

  task automatic run(input bit poke);
    int  beats, cyc;
    bit  prev_last;
    beats = 0; cyc = 0; prev_last = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", 64'(busy), 64'd1);
    while (busy) begin
      prev_last = 1'b0;
      if (res_valid) begin
        beats++;
        chk(int'(res_code) == beats, "R5 code order", 64'(res_code), 64'(beats));
        chk(int'(res_inl) == e_inl[beats], "R4 inl", 64'(res_inl), 64'(32'(e_inl[beats])));
        chk(int'(res_dnl) == e_dnl[beats], "R3 dnl", 64'(res_dnl), 64'(32'(e_dnl[beats])));
        prev_last = (int'(res_code) == LAST);
      end else if (beats > 0 && beats < LAST) begin
        chk(1'b0, "R5 gap in stream", 64'(beats), 64'(LAST));
      end
      start = poke && (cyc == 30);
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(prev_last, "R6 busy falls right after last beat", 64'(prev_last), 64'd1);
    chk(res_valid == 1'b0, "R6 no beat once idle", 64'(res_valid), 64'd0);
    chk(beats == LAST, "R5 beat count", 64'(beats), 64'(LAST));
    chk(shift_est == e_alpha, "R1 R2 shift", 64'(shift_est), 64'(e_alpha));
    chk(err == e_err, "R8 err", 64'(err), 64'(e_err));
    chk(inl_max == e_imax, "R7 inl max", 64'(inl_max), 64'(e_imax));
    chk(dnl_max == e_dmax, "R7 dnl max", 64'(dnl_max), 64'(e_dmax));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; start = 1'b0;
    wr_code = '0; wr_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", 64'(busy), 64'd0);
    chk(res_valid == 1'b0, "R10 res_valid", 64'(res_valid), 64'd0);
    chk(err == 1'b0, "R10 err", 64'(err), 64'd0);
    chk(shift_est == 32'd0, "R10 shift", 64'(shift_est), 64'd0);
    chk(inl_max == 32'd0 && dnl_max == 32'd0, "R10 maxima",
        {inl_max, dnl_max}, 64'd0);

    for (int v = 0; v < 5; v++) begin
      load_row(int'(VEC[v][79:64]), int'(VEC[v][63:48]),
               int'(VEC[v][47:32]), int'(VEC[v][31:16]));
      model();
      run(1'b0);
      chk(err == VEC[v][0], "R8 table flag", 64'(err), 64'(VEC[v][0]));
    end

    // R6: start while busy is ignored
    load_row(int'(VEC[0][79:64]), int'(VEC[0][63:48]),
             int'(VEC[0][47:32]), int'(VEC[0][31:16]));
    model();
    run(1'b1);

    // R8: one zero tally in bank A
    wr(1'b0, 9, 0);
    c1[9] = 0;
    model();
    chk(e_err == 1'b1, "R8 model sanity", 64'(e_err), 64'd1);
    run(1'b0);

    // R8: error clears on the next start when the data is good again
    c1[9] = 30 + (9 * 7) % 19;
    wr(1'b0, 9, int'(c1[9]));
    model();
    run(1'b0);
    chk(err == 1'b0, "R8 err cleared", 64'(err), 64'd0);

    // R9: oversized shifted-run code 0 makes every term bad
    wr(1'b1, 0, 60000);
    c2[0] = 60000;
    model();
    run(1'b0);
    chk(shift_est == 32'd0, "R9 shift zero", 64'(shift_est), 64'd0);
    chk(err == 1'b1, "R9 err", 64'(err), 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule